// File: doc/BRIEF.md
# DRAM Refresh Controller with Access Arbitration

This block keeps a 4096-row by 1024-column DRAM refreshed and shares the DRAM's multiplexed address and strobe pins between normal read/write accesses and refresh cycles. An interval timer raises a refresh request every 384 clock cycles. That gives 15.36 µs per row on a 25 MHz two-phase source, which stays inside the 64 ms budget for all 4096 rows. A 12-bit row counter names the row that the next refresh will restore. An arbiter decides which operation owns the pins next.

Each clock cycle is one phase of a two-phase scheme, and the phases alternate. New addresses are presented in phase-1 cycles, and the strobes fall only in phase-2 cycles.

- **Normal access:** the 22-bit address is split into a 12-bit row, which goes out first under RAS. It is followed by a 10-bit column, padded to the 12 pins, which goes out under CAS.
- **Refresh:** a RAS-only cycle that puts the refresh row counter on the pins.

The arbiter protects an access that is already running. It holds one read/write request that arrives while a refresh is in progress. When both kinds of request are waiting at a decision point, the normal access wins.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, and immediately after release, dram_ras_n, dram_cas_n and dram_we_n are 1, norm_active, ref_active and ref_pending are 0, and the refresh row counter is 0, so the first refresh after reset uses row 0.
- R2: ref_pending rises exactly 384 clock edges after reset release, and again every 384 edges after that, whatever accesses take place. It stays high until the refresh is granted.
- R3: A refresh cycle holds row-counter value on dram_addr for its whole duration. It drives dram_ras_n low for four cycles, starting one cycle after the grant, and keeps dram_cas_n and dram_we_n at 1 throughout.
- R4: The refresh row counter advances by one, modulo 4096, when each refresh cycle completes.
- R5: A normal access presents rw_addr[21:10] on dram_addr when dram_ras_n falls, and {2'b00, rw_addr[9:0]} when dram_cas_n falls. dram_cas_n never falls before dram_ras_n. dram_we_n is 0 for a write (rw_write=1) and 1 for a read.
- R6: A normal access that has started runs to completion before a refresh is granted, even if the refresh interval elapses during it.
- R7: A request (rw_req high for one cycle) that arrives during a refresh is held and served in the first grant slot after the refresh. Only one request is held, and a request that arrives while one is already held is dropped.
- R8: When a held read/write and a pending refresh meet at the same grant decision, the read/write is granted first. The refresh follows in the next grant slot.
- R9: Cycles alternate between phase 1 and phase 2, starting with phase 1 after reset. dram_addr changes only when a phase-1 cycle begins, and the strobes fall only in phase-2 cycles. A grant takes effect at the start of a phase-1 cycle.
- R10: norm_active and ref_active are never high together. After an operation releases both strobes, two idle cycles pass before the next grant takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one phase |
| rst_n | input | 1 | Synchronous active-low reset |
| rw_req | input | 1 | One-cycle pulse that starts a read/write |
| rw_addr | input | 22 | Word address: row in [21:10], column in [9:0] |
| rw_write | input | 1 | 1 = write, 0 = read, sampled with rw_req |
| dram_addr | output | 12 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| norm_active | output | 1 | A normal access owns the DRAM pins |
| ref_active | output | 1 | A refresh cycle owns the DRAM pins |
| ref_pending | output | 1 | A refresh interval has elapsed and is not yet granted |

## Verification
Normal accesses are driven with addresses whose row and column halves are all ones, all zeros, alternating bit patterns, and a one in only one half. These show whether the row and column fields are swapped, shifted or truncated on the pins, and whether reads and writes are told apart on the write strobe.

Refresh cycles are then set against traffic in three ways:
- a request that arrives mid-refresh, which shows that the request is queued;
- a request that arrives on the same edge as the interval, which shows the tie rule;
- an access granted just before the interval elapses, which shows that a running access is protected.

Each of these is checked on the exact cycle of grant. The refresh row is followed across successive refreshes and across a reset. This shows that the counter advances after each refresh and clears on reset, and that the interval timer keeps its 384-cycle period under contention.

// File: rtl/dref_pkg.sv
// Package: shared constants and types for the DRAM refresh controller.
// Assumes a 4096 x 1024 array reached through 12 multiplexed address pins.
package dref_pkg;

    localparam int ROW_W   = 12;               // row address bits
    localparam int COL_W   = 10;               // column address bits
    localparam int ADDR_W  = ROW_W + COL_W;    // full word address
    localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

    // Strobe sequence: six cycles (three phase pairs) per operation
    localparam int SEQ_LEN = 6;
    localparam int STEP_W  = $clog2(SEQ_LEN);

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_NORM = 2'd1,
        ARB_REFR = 2'd2
    } arb_state_t;

endpackage

// File: rtl/dref_interval_timer.sv
// Module: dref_interval_timer
// Counts clock cycles (either phase) and pulses tick for one cycle each time
// the count reaches LIMIT, then restarts from zero so the period never drifts.
// Assumes LIMIT >= 2.
module dref_interval_timer #(
    parameter int LIMIT = 384
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Terminal count: the next edge completes LIMIT cycles
    assign tick = (cnt == LAST);

    // Free-running interval counter with restart at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_restart_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

endmodule

// File: rtl/dref_row_counter.sv
// Module: dref_row_counter
// Holds the address of the next row to refresh. It advances by one when a
// refresh cycle completes and wraps modulo 2**ROW_W.
// Assumes advance is a single-cycle pulse.
module dref_row_counter #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);

    // Refresh row register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (advance) begin
            row <= row + 1'b1;
        end
    end

    assert_row_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(row));

    assert_row_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (row == $past(row) + 1'b1));

endmodule

// File: rtl/dref_arbiter.sv
// Module: dref_arbiter
// Decides who owns the DRAM pins. It keeps the refresh request pending until
// the refresh is granted, and holds one read/write request. Grants happen
// only from idle, at the end of a phase-2 cycle, so operations start in
// phase 1. A held read/write beats a pending refresh. A running operation is
// never pre-empted.
// Assumes seq_done pulses in the last cycle of each operation.
module dref_arbiter #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase2,      // current cycle is phase 2
    input  logic              rw_req,      // read/write initiated
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic              rw_write,
    input  logic              tick,        // refresh interval elapsed
    input  logic              seq_done,    // operation finishing this cycle
    output logic              grant_norm,
    output logic              grant_ref,   // refresh grant
    output logic              norm_active,
    output logic              ref_active,
    output logic              ref_pending, // refresh request
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_write
);

    import dref_pkg::*;

    arb_state_t state;
    logic       held;          // normal request waiting
    logic       decide;

    // Grant slot: idle and about to enter phase 1
    assign decide     = (state == ARB_IDLE) && phase2;
    assign grant_norm = decide && held;
    assign grant_ref  = decide && !held && ref_pending;

    assign norm_active = (state == ARB_NORM);
    assign ref_active  = (state == ARB_REFR);

    // Ownership state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            case (state)
                ARB_IDLE: begin
                    if (grant_norm)     state <= ARB_NORM;
                    else if (grant_ref) state <= ARB_REFR;
                end
                ARB_NORM, ARB_REFR: begin
                    if (seq_done) state <= ARB_IDLE;
                end
                default: state <= ARB_IDLE;
            endcase
        end
    end

    // Single-entry read/write queue; a request arriving while full is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= 1'b0;
            q_addr  <= '0;
            q_write <= 1'b0;
        end else if (grant_norm) begin
            held <= 1'b0;
        end else if (rw_req && !held) begin
            held    <= 1'b1;
            q_addr  <= rw_addr;
            q_write <= rw_write;
        end
    end

    // Refresh request latch: set by the interval, cleared by its grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pending <= 1'b0;
        end else begin
            ref_pending <= (ref_pending && !grant_ref) || tick;
        end
    end

    assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({norm_active, ref_active}));

    assert_tie_goes_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && held && ref_pending) |=> (norm_active && ref_pending));

    assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_active && !seq_done) |=> norm_active);

    assert_pending_until_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pending && !grant_ref) |=> ref_pending);

    assert_grant_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_norm || grant_ref) |-> (phase2 && !norm_active && !ref_active));

endmodule

// File: rtl/dref_strobe_seq.sv
// Module: dref_strobe_seq
// Drives the DRAM address and strobe pins for the granted operation over six
// cycles:
//   step0 (phase 1)  row address on the pins
//   step1 (phase 2)  RAS falls
//   step2 (phase 1)  column address on the pins (normal access only)
//   step3 (phase 2)  CAS falls (normal access only)
//   step4 (phase 1)  both strobes held
//   step5 (phase 2)  both strobes released; seq_done
// A refresh is RAS-only and puts the refresh row on the pins.
// Assumes a grant arrives at the edge that starts a phase-1 cycle.
module dref_strobe_seq #(
    parameter int ROW_W = 12,
    parameter int COL_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   grant_norm,
    input  logic                   grant_ref,
    input  logic                   norm_active,
    input  logic                   ref_active,
    input  logic [ROW_W+COL_W-1:0] acc_addr,
    input  logic                   acc_write,
    input  logic [ROW_W-1:0]       refresh_row,
    output logic [dref_pkg::PIN_W-1:0] dram_addr,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic                   seq_done
);

    import dref_pkg::*;

    localparam int ADDR_W = ROW_W + COL_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);
    localparam logic [STEP_W-1:0] RAS_ON    = STEP_W'(1);
    localparam logic [STEP_W-1:0] COL_LOAD  = STEP_W'(1);
    localparam logic [STEP_W-1:0] CAS_ON    = STEP_W'(3);
    localparam logic [STEP_W-1:0] HOLD_END  = STEP_W'(4);

    logic [STEP_W-1:0] step;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic              busy;

    assign busy     = norm_active || ref_active;
    assign seq_done = busy && (step == LAST_STEP);

    // Step counter: restarts on a grant, advances while an operation runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (grant_norm || grant_ref) begin
            step <= '0;
        end else if (busy && !seq_done) begin
            step <= step + 1'b1;
        end
    end

    // Column and direction latch, captured at the normal grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            wr_q  <= 1'b0;
        end else if (grant_norm) begin
            col_q <= acc_addr[COL_W-1:0];
            wr_q  <= acc_write;
        end
    end

    // Address pin register: row at the grant, column after the RAS phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_addr <= '0;
        end else if (grant_norm) begin
            dram_addr <= PIN_W'(acc_addr[ADDR_W-1:COL_W]);
        end else if (grant_ref) begin
            dram_addr <= PIN_W'(refresh_row);
        end else if (norm_active && step == COL_LOAD) begin
            dram_addr <= PIN_W'(col_q);
        end
    end

    // Strobe decode from the step counter
    always_comb begin
        ras_n = !(busy && step >= RAS_ON && step <= HOLD_END);
        cas_n = !(norm_active && step >= CAS_ON && step <= HOLD_END);
        we_n  = !(norm_active && wr_q);
    end

    assert_cas_inside_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_refresh_ras_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_active |-> (cas_n && we_n));

    assert_refresh_row_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_active && !seq_done) |=> $stable(dram_addr));

    assert_release_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_ctrl.sv
// Module: dram_refresh_ctrl (top)
// External refresh and access arbitration for a 4096 x 1024 DRAM. It ties
// together the two-phase generator, the interval timer, the refresh row
// counter, the arbiter and the strobe sequencer.
// Assumes each clk cycle is one phase and that phase 1 follows reset.
module dram_refresh_ctrl #(
    parameter int REFRESH_LIMIT = 384
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rw_req,
    input  logic [21:0] rw_addr,
    input  logic        rw_write,
    output logic [11:0] dram_addr,
    output logic        dram_ras_n,
    output logic        dram_cas_n,
    output logic        dram_we_n,
    output logic        norm_active,
    output logic        ref_active,
    output logic        ref_pending
);

    import dref_pkg::*;

    logic             phase2;
    logic             tick;
    logic             grant_norm;
    logic             grant_ref;
    logic             seq_done;
    logic [ROW_W-1:0] refresh_row;
    logic [ADDR_W-1:0] q_addr;
    logic             q_write;

    // Phase generator: phase 1 after reset, then alternating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase2 <= 1'b0;
        end else begin
            phase2 <= !phase2;
        end
    end

    dref_interval_timer #(
        .LIMIT (REFRESH_LIMIT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dref_row_counter #(
        .ROW_W (ROW_W)
    ) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ref_active && seq_done),
        .row     (refresh_row)
    );

    dref_arbiter #(
        .ADDR_W (ADDR_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase2      (phase2),
        .rw_req      (rw_req),
        .rw_addr     (rw_addr),
        .rw_write    (rw_write),
        .tick        (tick),
        .seq_done    (seq_done),
        .grant_norm  (grant_norm),
        .grant_ref   (grant_ref),
        .norm_active (norm_active),
        .ref_active  (ref_active),
        .ref_pending (ref_pending),
        .q_addr      (q_addr),
        .q_write     (q_write)
    );

    dref_strobe_seq #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_norm  (grant_norm),
        .grant_ref   (grant_ref),
        .norm_active (norm_active),
        .ref_active  (ref_active),
        .acc_addr    (q_addr),
        .acc_write   (q_write),
        .refresh_row (refresh_row),
        .dram_addr   (dram_addr),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .seq_done    (seq_done)
    );

    assert_strobe_fall_phase2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) || $fell(dram_cas_n)) |-> phase2);

    assert_addr_moves_phase1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 |-> $stable(dram_addr));

endmodule

// File: tb/dram_refresh_ctrl_test.sv
// Bench for dram_refresh_ctrl: a vector table of normal accesses, then
// directed checks of refresh timing, queueing, tie, protection and reset.
module dram_refresh_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rw_req = 1'b0;
    logic [21:0] rw_addr = '0;
    logic        rw_write = 1'b0;
    logic [11:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n;
    logic        norm_active, ref_active, ref_pending;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit run   = 1'b0;

    always #2.5 clk = !clk;   // 200 MHz

    dram_refresh_ctrl uut (
        .clk (clk), .rst_n (rst_n), .rw_req (rw_req), .rw_addr (rw_addr),
        .rw_write (rw_write), .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
        .norm_active (norm_active), .ref_active (ref_active),
        .ref_pending (ref_pending)
    );

    // Edge counter since reset release
    always @(posedge clk) begin
        if (!run) cyc <= 0;
        else      cyc <= cyc + 1;
    end

    // Vector: {addr[21:0], write, expected row[11:0], expected column pins[11:0]}
    localparam logic [46:0] VEC [7] = '{
        {22'h3FFFFF, 1'b1, 12'hFFF, 12'h3FF},
        {22'h000000, 1'b0, 12'h000, 12'h000},
        {22'h2AAAAA, 1'b1, 12'hAAA, 12'h2AA},
        {22'h155555, 1'b0, 12'h555, 12'h155},
        {22'h000400, 1'b1, 12'h001, 12'h000},
        {22'h3FFC00, 1'b0, 12'hFFF, 12'h000},
        {22'h0003FF, 1'b1, 12'h000, 12'h3FF}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [21:0] a, input logic w);
        rw_req = 1'b1; rw_addr = a; rw_write = w;
        @(negedge clk);
        rw_req = 1'b0;
    endtask

    // Normal access from the table, observed at the pins
    task automatic table_access(input logic [46:0] v);
        logic [11:0] row_seen = '0, col_seen = '0;
        logic        we_seen = 1'b1, prev_ras = 1'b1, prev_cas = 1'b1;
        bit          seen_active = 1'b0, order_ok = 1'b1, phase_ok = 1'b1;
        pulse_req(v[46:25], v[24]);
        while (!(seen_active && !norm_active)) begin
            if (norm_active) seen_active = 1'b1;
            if (prev_ras && !dram_ras_n) begin
                row_seen = dram_addr;
                if (cyc % 2 != 1) phase_ok = 1'b0;
            end
            if (prev_cas && !dram_cas_n) begin
                col_seen = dram_addr;
                we_seen  = dram_we_n;
                if (dram_ras_n) order_ok = 1'b0;
                if (cyc % 2 != 1) phase_ok = 1'b0;
            end
            prev_ras = dram_ras_n; prev_cas = dram_cas_n;
            @(negedge clk);
        end
        check(row_seen == v[23:12], "R5", "row at RAS fall", row_seen, v[23:12]);
        check(col_seen == v[11:0],  "R5", "column at CAS fall", col_seen, v[11:0]);
        check(we_seen == !v[24],    "R5", "we_n at CAS fall", we_seen, !v[24]);
        check(order_ok,             "R5", "CAS after RAS", order_ok, 1);
        check(phase_ok,             "R9", "strobes fall in phase 2", phase_ok, 1);
    endtask

    // Refresh granted at edge g with expected row
    task automatic check_refresh(input int g, input int row);
        bit ok = 1'b1;
        wait_to(g);
        check(ref_active && !norm_active, "R3", "refresh owns pins", ref_active, 1);
        check(dram_addr == row, "R4", "refresh row on pins", dram_addr, row);
        check(dram_ras_n, "R9", "RAS high in grant phase 1", dram_ras_n, 1);
        for (int k = 1; k <= 4; k++) begin
            wait_to(g + k);
            if (dram_ras_n || !dram_cas_n || !dram_we_n || dram_addr != row) ok = 1'b0;
        end
        check(ok, "R3", "RAS-only cycle body", ok, 1);
        wait_to(g + 5);
        check(dram_ras_n && dram_cas_n, "R10", "strobes released", dram_ras_n, 1);
        wait_to(g + 6);
        check(!ref_active, "R10", "refresh finished", ref_active, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
        check(!norm_active && !ref_active, "R1", "no owner in reset",
              {norm_active, ref_active}, 0);
        check(!ref_pending, "R1", "no refresh pending", ref_pending, 0);
        rst_n = 1'b1; run = 1'b1;

        foreach (VEC[i]) table_access(VEC[i]);

        // R2: first interval exactly 384 edges
        wait_to(383);
        check(!ref_pending, "R2", "pending before 384", ref_pending, 0);
        wait_to(384);
        check(ref_pending && !ref_active, "R2", "pending at 384", ref_pending, 1);
        wait_to(385);
        check(ref_pending, "R2", "pending held until grant", ref_pending, 1);
        fork
            check_refresh(386, 0);
            begin
                // R7: request arriving mid-refresh is queued
                wait_to(388);
                pulse_req(22'h3C0F0F, 1'b0);
            end
        join
        wait_to(393);
        check(!norm_active, "R7", "queued access waits two idle cycles", norm_active, 0);
        wait_to(394);
        check(norm_active && dram_addr == 12'hF03, "R7", "queued row after refresh",
              dram_addr, 12'hF03);
        wait_to(396);
        check(dram_addr == 12'h30F, "R7", "queued column", dram_addr, 12'h30F);

        // R2/R4: second interval, next row
        wait_to(767);
        check(!ref_pending, "R2", "pending before 768", ref_pending, 0);
        check_refresh(770, 1);

        // R8: request and interval meet at the same edge
        wait_to(1151);
        pulse_req(22'h123456, 1'b1);
        check(ref_pending && !norm_active, "R8", "both waiting", ref_pending, 1);
        wait_to(1154);
        check(norm_active && !ref_active, "R8", "normal wins tie", norm_active, 1);
        check(dram_addr == 12'h48D, "R8", "tie winner row", dram_addr, 12'h48D);
        check(ref_pending, "R8", "refresh still pending", ref_pending, 1);
        check_refresh(1162, 2);

        // R6: interval elapses during a running access
        wait_to(1532);
        pulse_req(22'h0ABCDE, 1'b0);
        wait_to(1536);
        check(norm_active && ref_pending, "R6", "access runs with refresh pending",
              norm_active, 1);
        wait_to(1539);
        check(norm_active && !ref_active, "R6", "access completes first", ref_active, 0);
        check_refresh(1542, 3);

        // R1: reset mid-operation clears everything including the row counter
        wait_to(1550);
        pulse_req(22'h000001, 1'b1);
        wait_to(1553);
        rst_n = 1'b0; run = 1'b0;
        @(negedge clk); @(negedge clk);
        check(dram_ras_n && dram_cas_n && !norm_active && !ref_active,
              "R1", "idle after mid-access reset", {dram_ras_n, norm_active}, 2'b10);
        rst_n = 1'b1; run = 1'b1;
        check_refresh(386, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule